// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences the operating power mode of a processor core and drives the controls for its clock source. It tracks five modes: full-on, where the core runs from the PLL; active and relaxed, where the PLL is bypassed and the core runs from the input clock divided by two; and sleep and deep sleep, where the core clock is gated. Software moves the core between the running modes, and into either low-power mode, with a request that carries a 3-bit target code.

The two low-power modes wake differently. Sleep keeps the PLL powered, and it wakes on a peripheral interrupt or when an internal wake timer runs out. Deep sleep powers the PLL down and ignores every wake source except reset and a real-time-clock event. A wake returns the core to the running mode it left. Full-on is entered only when the PLL reports lock, so after reset or a wake from deep sleep the controller first waits for lock. That wait is bounded by a parameterised count. If lock never arrives, the controller falls back to active and raises a sticky timeout flag.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While reset is held, and after its release until lock is seen, the controller is in the lock-wait state. There `mode` reads 1, `pll_en`, `pll_bypass`, `core_clk_en` and `clk_div2` are all 1, and `lock_timeout` is 0. The first clock edge that samples `pll_locked` high moves it to full-on.
- R2: If `pll_locked` stays low for LOCK_WAIT consecutive edges in lock wait, then at the LOCK_WAIT-th edge the mode becomes active (1) and `lock_timeout` goes high. The flag stays high until reset.
- R3: The mode codes are full-on=0, active=1, relaxed=2, sleep=3, deep sleep=4. In a running mode, an `sw_req` with code 0 to 4 changes the mode at the same edge that samples it. Codes 5 to 7 leave the mode unchanged, and `mode` never shows a code above 4.
- R4: The clock outputs follow the mode as {`pll_en`,`pll_bypass`,`core_clk_en`,`clk_div2`}: full-on 1010, active 1111, relaxed 0111, sleep 1101, deep sleep 0101.
- R5: A request for full-on goes straight to full-on when `pll_locked` is high at that edge. Otherwise it goes to lock wait, which reads as mode 1 and does not accept software requests.
- R6: Entering sleep or deep sleep latches the running mode as the wake target.
- R7: In sleep, an `irq_req` at an edge returns the core to the wake target at that edge, going through lock wait if the target is full-on and `pll_locked` is low.
- R8: Entering sleep loads a wake timer with WAKE_CYCLES. When no interrupt comes, the core wakes at the (WAKE_CYCLES+1)-th edge after the entry edge.
- R9: Deep sleep ignores `irq_req`, the wake timer and `sw_req`. The mode stays 4 until `rtc_evt` or reset.
- R10: On `rtc_evt` in deep sleep, a full-on target always goes through lock wait, whatever `pll_locked` shows. An active or relaxed target is entered directly.
- R11: Sleep ignores `sw_req` and `rtc_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (input reference clock) |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Peripheral interrupt request (wakes from sleep) |
| rtc_evt | input | 1 | Real-time-clock event (wakes from deep sleep) |
| sw_req | input | 1 | Software mode request strobe |
| sw_mode | input | 3 | Requested mode code |
| pll_locked | input | 1 | PLL lock indication |
| mode | output | 3 | Current mode code |
| pll_en | output | 1 | PLL power enable |
| pll_bypass | output | 1 | 1 selects the input clock instead of the PLL |
| core_clk_en | output | 1 | Core clock gate enable |
| clk_div2 | output | 1 | 1 divides the selected clock by two |
| lock_timeout | output | 1 | Sticky flag: lock wait expired without lock |

## Verification
The properties assume that every input is synchronous to `clk`. They also assume that `pll_locked` is a level the controller may sample at any edge, and they do not tie it to `pll_en`. The stimulus changes inputs only on the falling edge and gives each strobe one full cycle. It also holds `pll_locked` high while the PLL is off in deep sleep, which shows that the wake path still waits for lock rather than trusting that stale level. No wake event is raised in the same cycle as a mode request, so the wake target is always well defined.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int LOCK_WAIT   = 16,
  parameter int WAKE_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req,
  input  logic       rtc_evt,
  input  logic       sw_req,
  input  logic [2:0] sw_mode,
  input  logic       pll_locked,
  output logic [2:0] mode,
  output logic       pll_en,
  output logic       pll_bypass,
  output logic       core_clk_en,
  output logic       clk_div2,
  output logic       lock_timeout
);
  localparam int LW = $clog2(LOCK_WAIT + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [LW-1:0] CNT_LAST  = LW'(LOCK_WAIT - 1);
  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CYCLES);

  typedef enum logic [2:0] {
    S_FULL = 3'd0, S_ACT = 3'd1, S_REL = 3'd2,
    S_SLP  = 3'd3, S_DEEP = 3'd4, S_LOCK = 3'd5
  } st_t;

  st_t st, nxt, tgt;
  logic [LW-1:0] cnt;
  logic [WW-1:0] wt;
  logic running;
  st_t  to_full;

  assign running = (st == S_FULL) || (st == S_ACT) || (st == S_REL);
  assign to_full = pll_locked ? S_FULL : S_LOCK;

  always_comb begin
    nxt = st;
    unique case (st)
      S_LOCK: begin
        if (pll_locked)        nxt = S_FULL;
        else if (cnt == CNT_LAST) nxt = S_ACT;
      end
      S_FULL, S_ACT, S_REL: begin
        if (sw_req) begin
          case (sw_mode)
            3'd0: nxt = to_full;
            3'd1: nxt = S_ACT;
            3'd2: nxt = S_REL;
            3'd3: nxt = S_SLP;
            3'd4: nxt = S_DEEP;
            default: nxt = st;
          endcase
        end
      end
      S_SLP: begin
        if (irq_req || wt == '0) nxt = (tgt == S_FULL) ? to_full : tgt;
      end
      S_DEEP: begin
        if (rtc_evt) nxt = (tgt == S_FULL) ? S_LOCK : tgt;
      end
      default: nxt = S_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_LOCK;
      tgt          <= S_FULL;
      cnt          <= '0;
      wt           <= '0;
      lock_timeout <= 1'b0;
    end else begin
      st  <= nxt;
      cnt <= (st == S_LOCK && nxt == S_LOCK) ? cnt + 1'b1 : '0;
      if (st == S_LOCK && nxt == S_ACT) lock_timeout <= 1'b1;
      if (running && (nxt == S_SLP || nxt == S_DEEP)) tgt <= st;
      if (nxt == S_SLP && st != S_SLP) wt <= WAKE_LOAD;
      else if (st == S_SLP && wt != '0) wt <= wt - 1'b1;
    end
  end

  assign mode        = (st == S_LOCK) ? 3'd1 : st;
  assign pll_en      = !(st == S_REL || st == S_DEEP);
  assign pll_bypass  = (st != S_FULL);
  assign clk_div2    = (st != S_FULL);
  assign core_clk_en = !(st == S_SLP || st == S_DEEP);
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       rtc_evt,
  input logic       pll_locked,
  input logic [2:0] mode,
  input logic       pll_en,
  input logic       pll_bypass,
  input logic       core_clk_en,
  input logic       clk_div2,
  input logic       lock_timeout
);
  assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  assert_clk_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en != (mode == 3'd3 || mode == 3'd4));

  assert_deep_pll_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> !pll_en);

  assert_pll_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_bypass |-> (mode == 3'd0 && pll_en && !clk_div2));

  assert_full_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && $past(mode) != 3'd0) |-> $past(pll_locked));

  assert_timeout_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_timeout) |-> mode == 3'd1);

  assert_sleep_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && irq_req) |=> mode <= 3'd2);

  assert_deep_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !rtc_evt) |=> mode == 3'd4);
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rtc_evt(rtc_evt),
  .pll_locked(pll_locked), .mode(mode), .pll_en(pll_en),
  .pll_bypass(pll_bypass), .core_clk_en(core_clk_en),
  .clk_div2(clk_div2), .lock_timeout(lock_timeout)
);

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  localparam int CLK_P = 10;
  localparam int LW    = 16;
  localparam int WK    = 20;

  logic clk = 0, rst_n = 0, irq_req = 0, rtc_evt = 0, sw_req = 0, pll_locked = 0;
  logic [2:0] sw_mode = '0;
  logic [2:0] mode;
  logic pll_en, pll_bypass, core_clk_en, clk_div2, lock_timeout;
  int n_chk = 0, n_bad = 0;

  pwr_mode_ctl #(.LOCK_WAIT(LW), .WAKE_CYCLES(WK)) i_pwr_mode_ctl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rtc_evt(rtc_evt),
    .sw_req(sw_req), .sw_mode(sw_mode), .pll_locked(pll_locked),
    .mode(mode), .pll_en(pll_en), .pll_bypass(pll_bypass),
    .core_clk_en(core_clk_en), .clk_div2(clk_div2), .lock_timeout(lock_timeout));

  always #(CLK_P/2) clk = ~clk;

  // {code[10:8], lock[7], exp mode[6:4], exp {en,byp,ce,div}[3:0]}
  localparam logic [10:0] VEC [10] = '{
    {3'd1, 1'b1, 3'd1, 4'b1111},
    {3'd2, 1'b1, 3'd2, 4'b0111},
    {3'd1, 1'b0, 3'd1, 4'b1111},
    {3'd0, 1'b1, 3'd0, 4'b1010},
    {3'd5, 1'b1, 3'd0, 4'b1010},
    {3'd7, 1'b1, 3'd0, 4'b1010},
    {3'd2, 1'b1, 3'd2, 4'b0111},
    {3'd6, 1'b1, 3'd2, 4'b0111},
    {3'd0, 1'b0, 3'd1, 4'b1111},
    {3'd2, 1'b1, 3'd0, 4'b1010}
  };

  task automatic chk(string req, logic [2:0] em, logic [3:0] eclk);
    n_chk++;
    if (mode !== em || {pll_en, pll_bypass, core_clk_en, clk_div2} !== eclk) begin
      n_bad++;
      $display("FAIL %s: mode=%0d clk=%b expected mode=%0d clk=%b",
               req, mode, {pll_en, pll_bypass, core_clk_en, clk_div2}, em, eclk);
    end
  endtask

  task automatic chk_to(string req, logic exp);
    n_chk++;
    if (lock_timeout !== exp) begin
      n_bad++;
      $display("FAIL %s: lock_timeout=%b expected %b", req, lock_timeout, exp);
    end
  endtask

  task automatic req(logic [2:0] code);
    sw_mode = code; sw_req = 1;
    @(negedge clk); sw_req = 0;
  endtask

  task automatic pulse_irq();
    irq_req = 1; @(negedge clk); irq_req = 0;
  endtask

  task automatic pulse_rtc();
    rtc_evt = 1; @(negedge clk); rtc_evt = 0;
  endtask

  task automatic do_reset(logic lk);
    rst_n = 0; pll_locked = lk;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset and lock wait
    do_reset(1'b0);
    @(negedge clk);
    chk("R1 lock wait", 3'd1, 4'b1111);
    chk_to("R1 timeout clear", 1'b0);
    pll_locked = 1; @(negedge clk);
    chk("R1 lock to full-on", 3'd0, 4'b1010);

    // R3 R4 R5 request table
    foreach (VEC[i]) begin
      pll_locked = VEC[i][7];
      req(VEC[i][10:8]);
      chk($sformatf("R3/R4/R5 vector %0d", i), VEC[i][6:4], VEC[i][3:0]);
    end
    pll_locked = 1;

    // R6 R8 sleep wakes on timer to full-on
    req(3'd3);
    chk("R4 R6 sleep entry", 3'd3, 4'b1101);
    repeat (WK) @(negedge clk);
    chk("R8 still asleep before expiry", 3'd3, 4'b1101);
    @(negedge clk);
    chk("R8 timer wake to full-on", 3'd0, 4'b1010);

    // R11 R7 sleep from active, interrupt wake
    req(3'd1);
    req(3'd3);
    chk("R6 sleep from active", 3'd3, 4'b1101);
    req(3'd0);
    chk("R11 sw request ignored in sleep", 3'd3, 4'b1101);
    pulse_rtc();
    chk("R11 rtc ignored in sleep", 3'd3, 4'b1101);
    pulse_irq();
    chk("R7 irq wake to active", 3'd1, 4'b1111);

    // R9 R10 deep sleep from full-on
    req(3'd0);
    req(3'd4);
    chk("R4 deep entry", 3'd4, 4'b0101);
    pulse_irq();
    req(3'd0);
    repeat (WK + 5) @(negedge clk);
    chk("R9 deep ignores irq, sw, timer", 3'd4, 4'b0101);
    pulse_rtc();
    chk("R10 full-on target waits for lock", 3'd1, 4'b1111);
    @(negedge clk);
    chk("R10 lock then full-on", 3'd0, 4'b1010);

    // R10 active target direct
    req(3'd1);
    req(3'd4);
    pll_locked = 0;
    pulse_rtc();
    chk("R10 deep wake to active", 3'd1, 4'b1111);
    pll_locked = 1;
    repeat (2) @(negedge clk);
    chk("R10 active is not lock wait", 3'd1, 4'b1111);

    // R10 relaxed target direct
    req(3'd2);
    req(3'd4);
    pulse_rtc();
    chk("R10 deep wake to relaxed", 3'd2, 4'b0111);

    // R2 lock timeout
    do_reset(1'b0);
    repeat (LW - 1) @(negedge clk);
    chk_to("R2 no timeout before limit", 1'b0);
    chk("R2 still waiting", 3'd1, 4'b1111);
    @(negedge clk);
    chk_to("R2 timeout raised", 1'b1);
    chk("R2 fallback active", 3'd1, 4'b1111);
    pll_locked = 1;
    repeat (2) @(negedge clk);
    chk_to("R2 flag sticky", 1'b1);
    chk("R2 stays active after late lock", 3'd1, 4'b1111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule